// File: doc/BRIEF.md
# Early/Late Gate Bit Synchronizer

This block recovers a bit clock from a serial binary input. It uses a fast sample clock whose rate is an even multiple of the bit rate. A symbol counter splits each recovered bit period into an early half and a late half. Three running sums, each counting +1 for a one sample and -1 for a zero sample, integrate the early half, the late half and the whole symbol.

At every symbol end the block forms a phase error. The error is the early sum minus the late sum, and it is negated when the whole-symbol sum decides the bit was a zero. The error is added to a signed, saturating accumulator that acts as a first-order loop filter. When the accumulator magnitude rises strictly above a programmable threshold, the symbol clock is corrected and the accumulator is cleared. A positive total means the local clock is late, so the next symbol is shortened by the programmed step. A negative total lengthens the next symbol by the same step.

A narrow threshold gives fast tracking, and a wide threshold smooths the response. A large step gives fast acquisition, and a small step gives low jitter once aligned. Feeding a reference clock into the data input turns the block into a plain clock-phase tracker.

Top module: `elg_bit_sync`

## Requirements
- R1: While rst_ni is low, data_clk_o is high at once, without waiting for a clock edge, and the counter sits at the start of a symbol. After release, the first rising edge of data_clk_o comes ratio_i sample clocks later.
- R2: With no correction pending, data_clk_o has a period of exactly ratio_i sample clocks and is high for the first ratio_i/2 samples of each symbol. This holds for every even ratio_i from 4 to 254.
- R3: Each sample counts +1 when data_i=1 and -1 when data_i=0. The per-symbol error is (early sum - late sum) when the whole-symbol sum is zero or above, and (late sum - early sum) otherwise.
- R4: A correction fires only when the magnitude of the accumulated error is strictly greater than thresh_i. The error of symbol n makes the decision, and the correction changes the length of symbol n+1.
- R5: A correction with a positive accumulated error shortens the next symbol to ratio_i - step_i samples.
- R6: A correction with a negative accumulated error lengthens the next symbol to ratio_i + step_i samples.
- R7: The accumulator is cleared when a correction fires. Once the input is aligned, the period returns to ratio_i and stays there.
- R8: With step_i = 0 no correction ever fires, whatever the accumulated error is.
- R9: A constant data_i gives zero error, so the period never changes, even with thresh_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial binary data, sampled on each rising clk_i edge |
| ratio_i | input | 8 | Sample clocks per symbol; an even value from 4 to 254 |
| thresh_i | input | 16 | Error magnitude that must be exceeded to trigger a correction |
| step_i | input | 8 | Correction size in samples; 0 disables tracking; must be less than ratio_i/2 |
| data_clk_o | output | 1 | Recovered bit clock, high during the early half of each symbol |

## Verification
The bench drives alternating data that is offset so the local clock is either late or early. Each run predicts which symbol is shortened or lengthened and compares every measured period and high time.

- Thresholds 7 and 8 with an error of 4 per symbol separate a strict compare from a non-strict one: a design using greater-or-equal corrects one symbol early.
- A late input and an early input separate the two directions: a sign swap lengthens where the bench expects a shorter symbol.
- The periods after each correction expose an accumulator that is not cleared, because a second, unexpected correction shows up.
- Runs with a zero step and with constant data must show no correction at all, which catches a missing step gate and a wrong zero-error case.
- Ratio 4 with a step of 1, and ratio 254, check both ends of the counter range.

// File: rtl/elg_pkg.sv
package elg_pkg;
  typedef enum logic [1:0] {
    LEN_NOM   = 2'd0,
    LEN_SHORT = 2'd1,
    LEN_LONG  = 2'd2
  } len_mode_e;

  typedef enum logic {
    DIR_ADV = 1'b0,
    DIR_RET = 1'b1
  } adj_dir_e;
endpackage

// File: rtl/elg_timebase.sv
module elg_timebase
  import elg_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int STEP_W  = 8,
  parameter int CNT_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic               adj_vld_i,
  input  adj_dir_e           adj_dir_i,
  output logic               early_o,
  output logic               sym_end_o
);
  logic [CNT_W-1:0] cnt_q, base_len, half_len, step_ext, sym_len, last_idx;
  len_mode_e mode_q, mode_d;

  always_comb begin
    base_len = CNT_W'(ratio_i);
    step_ext = CNT_W'(step_i);
    half_len = base_len >> 1;
    unique case (mode_q)
      LEN_SHORT: sym_len = base_len - step_ext;
      LEN_LONG:  sym_len = base_len + step_ext;
      default:   sym_len = base_len;
    endcase
    last_idx = sym_len - CNT_W'(1);
  end

  assign sym_end_o = (cnt_q >= last_idx);
  assign early_o   = (cnt_q < half_len);

  always_comb begin
    mode_d = sym_end_o ? LEN_NOM : mode_q;
    if (adj_vld_i) mode_d = (adj_dir_i == DIR_ADV) ? LEN_SHORT : LEN_LONG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= LEN_NOM;
    end else begin
      cnt_q  <= sym_end_o ? '0 : cnt_q + CNT_W'(1);
      mode_q <= mode_d;
    end
  end

  // R4 correction lands one sample into the symbol it resizes
  adj_mid_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_vld_i |-> cnt_q == CNT_W'(1));
endmodule

// File: rtl/elg_phase_det.sv
module elg_phase_det #(
  parameter int SUM_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    data_i,
  input  logic                    early_i,
  input  logic                    sym_end_i,
  output logic                    err_vld_o,
  output logic signed [SUM_W-1:0] err_o
);
  localparam logic signed [SUM_W-1:0] P_ONE = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] M_ONE = SUM_W'(-1);

  logic signed [SUM_W-1:0] se_q, sl_q, st_q, smp, se_n, sl_n, st_n, diff;

  always_comb begin
    smp  = data_i ? P_ONE : M_ONE;
    se_n = early_i ? se_q + smp : se_q;
    sl_n = early_i ? sl_q : sl_q + smp;
    st_n = st_q + smp;
    diff = se_n - sl_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_q      <= '0;
      sl_q      <= '0;
      st_q      <= '0;
      err_o     <= '0;
      err_vld_o <= 1'b0;
    end else if (sym_end_i) begin
      se_q      <= '0;
      sl_q      <= '0;
      st_q      <= '0;
      // a tie in the whole-symbol sum counts as a one
      err_o     <= (st_n >= 0) ? diff : -diff;
      err_vld_o <= 1'b1;
    end else begin
      se_q      <= se_n;
      sl_q      <= sl_n;
      st_q      <= st_n;
      err_vld_o <= 1'b0;
    end
  end

  // R3
  sum_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == se_q + sl_q);
  // R3
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |=> !err_vld_o);
endmodule

// File: rtl/elg_loop_filter.sv
module elg_loop_filter
  import elg_pkg::*;
#(
  parameter int THR_W  = 16,
  parameter int STEP_W = 8,
  parameter int SUM_W  = 11,
  parameter int ACC_W  = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_vld_i,
  input  logic signed [SUM_W-1:0] err_i,
  input  logic [THR_W-1:0]        thresh_i,
  input  logic [STEP_W-1:0]       step_i,
  output logic                    adj_vld_o,
  output adj_dir_e                adj_dir_o
);
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'(2**(ACC_W-1) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - (ACC_W+1)'(1);

  logic signed [ACC_W-1:0] acc_q, acc_sat;
  logic signed [ACC_W:0]   sum_w;
  logic [ACC_W-1:0]        mag;
  logic                    fire;

  always_comb begin
    sum_w = (ACC_W+1)'(acc_q) + (ACC_W+1)'(err_i);
    if (sum_w > SAT_HI)      acc_sat = ACC_W'(SAT_HI);
    else if (sum_w < SAT_LO) acc_sat = ACC_W'(SAT_LO);
    else                     acc_sat = ACC_W'(sum_w);
    mag  = (acc_sat < 0) ? ACC_W'(-acc_sat) : ACC_W'(acc_sat);
    fire = err_vld_i && (step_i != '0) && (mag > ACC_W'(thresh_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      adj_vld_o <= 1'b0;
      adj_dir_o <= DIR_ADV;
    end else if (err_vld_i) begin
      acc_q     <= fire ? '0 : acc_sat;
      adj_vld_o <= fire;
      adj_dir_o <= (acc_sat > 0) ? DIR_ADV : DIR_RET;
    end else begin
      adj_vld_o <= 1'b0;
    end
  end

  // R8
  no_step_adj_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_vld_o |-> $past(step_i) != '0);
  // R7
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_vld_o |-> acc_q == '0);
  // R4
  adj_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_vld_o |=> !adj_vld_o);
endmodule

// File: rtl/elg_bit_sync.sv
module elg_bit_sync
  import elg_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int THR_W   = 16,
  parameter int STEP_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [THR_W-1:0]   thresh_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic               data_clk_o
);
  localparam int CNT_W = RATIO_W + 2;
  localparam int SUM_W = CNT_W + 1;
  localparam int ACC_W = THR_W + 2;

  logic                    early, sym_end, err_vld, adj_vld;
  logic signed [SUM_W-1:0] err;
  adj_dir_e                adj_dir;

  elg_timebase #(.RATIO_W(RATIO_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .step_i(step_i),
    .adj_vld_i(adj_vld), .adj_dir_i(adj_dir),
    .early_o(early), .sym_end_o(sym_end)
  );

  elg_phase_det #(.SUM_W(SUM_W)) u_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .early_i(early), .sym_end_i(sym_end),
    .err_vld_o(err_vld), .err_o(err)
  );

  elg_loop_filter #(.THR_W(THR_W), .STEP_W(STEP_W), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_lf (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_vld_i(err_vld), .err_i(err),
    .thresh_i(thresh_i), .step_i(step_i),
    .adj_vld_o(adj_vld), .adj_dir_o(adj_dir)
  );

  assign data_clk_o = early;

  // R2 symbol errors arrive at the start of the early half
  err_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld |-> data_clk_o);
endmodule

// File: tb/elg_bit_sync_bench.sv
module elg_bit_sync_bench;
  logic        clk_i = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_i = 1'b0;
  logic [7:0]  ratio_i = 8'd8;
  logic [15:0] thresh_i = '0;
  logic [7:0]  step_i = '0;
  logic        data_clk_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int half_exp = 4;
  string cur_tag = "";

  // monitor state
  int  m_idx, last_rise, hi_cnt;
  logic prev_clk;

  always #5 clk_i = ~clk_i;

  elg_bit_sync u_elg_bit_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .data_i(data_i), .ratio_i(ratio_i),
    .thresh_i(thresh_i), .step_i(step_i), .data_clk_o(data_clk_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: measure rise-to-rise period and high time
  always @(negedge clk_i) begin
    if (!rst_n) begin
      m_idx = 1; last_rise = 0; hi_cnt = 1; prev_clk = 1'b1;
    end else begin
      if (data_clk_o && !prev_clk) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check({cur_tag, " period"}, m_idx - last_rise, e);
          check({cur_tag, " R2 high time"}, hi_cnt, half_exp);
        end
        last_rise = m_idx;
        hi_cnt = 0;
      end
      if (data_clk_o) hi_cnt++;
      prev_clk = data_clk_o;
      m_idx++;
    end
  end

  function automatic logic bit_at(input int m, input int r, input int k, input bit cst);
    if (cst) return 1'b1;
    return logic'(((m + r - k) / r) % 2);
  endfunction

  task automatic run_case(input string tag, input int r, input int thr, input int st,
                          input int k, input bit cst, input int n, input int ex[8]);
    @(negedge clk_i); #1;
    rst_n = 1'b0;
    #1 check({tag, " R1 async reset clk high"}, int'(data_clk_o), 1);
    ratio_i = 8'(r); thresh_i = 16'(thr); step_i = 8'(st);
    half_exp = r / 2; cur_tag = tag;
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    #1 check({tag, " R1 held in reset"}, int'(data_clk_o), 1);
    for (int i = 0; i < n; i++) exp_q.push_back(ex[i]);
    data_i = bit_at(0, r, k, cst);
    rst_n = 1'b1;
    for (int m = 1; m < 4000 && exp_q.size() > 0; m++) begin
      @(negedge clk_i); #1;
      data_i = bit_at(m, r, k, cst);
    end
    if (exp_q.size() > 0) check({tag, " R2 periods seen"}, exp_q.size(), 0);
  endtask

  initial begin
    // R8 zero step: late input never corrected
    run_case("R8 step zero", 8, 0, 0, 6, 1'b0, 6, '{8, 8, 8, 8, 8, 8, 0, 0});
    // R3 R5 R7 late by 2: error +4 per symbol, fires after third symbol
    run_case("R3 R5 R7 advance", 8, 10, 2, 6, 1'b0, 7, '{8, 8, 8, 6, 8, 8, 8, 0});
    // R4 strict compare: 8 > 7 fires one symbol earlier than 8 > 8
    run_case("R4 thresh7", 8, 7, 2, 6, 1'b0, 6, '{8, 8, 6, 8, 8, 8, 0, 0});
    run_case("R4 thresh8", 8, 8, 2, 6, 1'b0, 6, '{8, 8, 8, 6, 8, 8, 0, 0});
    // R6 early by 2: error -4 per symbol
    run_case("R6 retard", 8, 10, 2, 2, 1'b0, 6, '{8, 8, 8, 10, 8, 8, 0, 0});
    // R2 R5 ratio 16, late by 4
    run_case("R2 R5 ratio16", 16, 20, 4, 12, 1'b0, 6, '{16, 16, 16, 12, 16, 16, 0, 0});
    // R9 constant ones, zero threshold
    run_case("R9 constant", 8, 0, 2, 0, 1'b1, 6, '{8, 8, 8, 8, 8, 8, 0, 0});
    // R2 R4 smallest ratio with unit step
    run_case("R2 R4 ratio4", 4, 3, 1, 3, 1'b0, 6, '{4, 4, 3, 4, 4, 4, 0, 0});
    // R2 largest ratio, aligned
    run_case("R2 ratio254", 254, 0, 0, 0, 1'b0, 2, '{254, 254, 0, 0, 0, 0, 0, 0});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule